// File: doc/BRIEF.md
# Hub Downstream Port Configuration Register

This block holds the configuration for the downstream-port power logic of a USB hub. It is one register on a simple indexed bus that has an address, a write strobe with write data, and a read strobe with read data. The register contains three fields:

- an active-low run bit that holds the hub core in reset;
- a two-bit code that selects how many downstream ports are active;
- a bit that joins all ports into one shared power domain.

When the power-on reset is asserted, the port-count code is loaded from the inverse of two active-low strap pins. If the straps are left pulled high, all four ports are active.

The block turns the register contents into these outputs:

- a hub-hold output;
- a port-enable mask;
- active-low per-port power-enable pins, built from per-port power requests;
- active-high over-current flags, built from active-low sense pins.

Every port that the count code leaves out is quiet: its sense input is ignored, its flag stays 0 and its power-enable pin is driven low. In joined mode:

- the sense inputs of the active ports are combined into one shared fault, which every active port reports;
- the power requests of the active ports are combined into one shared enable, which drives every active port's pin.

Top module: `hub_port_cfg`

## Requirements
- R1: While `por_n` is low the register takes the value with bit 7 = 0, bits 6:5 = the bitwise inverse of `strap_n[1:0]` and all other bits 0. With both straps high the value is 0x00.
- R2: After `por_n` rises, changes on `strap_n` have no effect on the register. Only a write can change it.
- R3: A write (`bus_wr` = 1) with `bus_addr` = 0xF7 loads bits 7, 6:5 and 0 from `bus_wdata` at the next rising clock edge. Writes to any other address leave the register unchanged.
- R4: While `bus_rd` = 1 and `bus_addr` = 0xF7, `bus_rdata` shows the register in the same cycle, with bits 4:1 always 0. At all other times `bus_rdata` is 0.
- R5: `hub_hold` is the inverse of register bit 7 (1 = hub held in reset).
- R6: `port_en` is decoded from bits 6:5 as follows: 00 gives 4'b1111, 01 gives 4'b0111, 10 gives 4'b0011, and the reserved code 11 gives 4'b0000.
- R7: With bit 0 = 0, `pwr_en_n[i]` is `~pwr_req[i]` for an enabled port and 0 for a disabled port.
- R8: With bit 0 = 0, `oc_flag[i]` is `~oc_sense_n[i]` for an enabled port and 0 for a disabled port.
- R9: With bit 0 = 1, a shared fault is the OR of `~oc_sense_n[i]` over the enabled ports. Every enabled port's `oc_flag` equals this shared fault, and every disabled port's flag is 0.
- R10: With bit 0 = 1, a shared request is the OR of `pwr_req[i]` over the enabled ports. Every enabled port's `pwr_en_n` equals the inverse of this shared request, and every disabled port's pin is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| strap_n | input | 2 | Active-low port-count straps, sampled during power-on reset |
| bus_addr | input | 8 | Register index |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 8 | Read data, valid in the same cycle as the read strobe |
| pwr_req | input | 4 | Per-port power requests from the hub core, active high |
| oc_sense_n | input | 4 | Per-port over-current sense, active low |
| hub_hold | output | 1 | Holds the hub core in reset when 1 |
| port_en | output | 4 | Enabled-port mask |
| pwr_en_n | output | 4 | Per-port power enable, active low |
| oc_flag | output | 4 | Per-port over-current flag, active high |

## Verification
The bus has no back-pressure and no data stream, so the properties take the strobes, address and data as settled around each rising edge. They also assume that a write and a read never need arbitration. The stimulus meets this by changing every input only on falling edges, or in short steps between edges, and by holding a strobe for exactly one clock. The stability property assumes that only a hit write can move the outputs that come from the register. For that reason the straps are changed only after reset, where they must have no effect. The gating properties are purely combinational, so the sweep moves requests and sense pins freely between clock edges.

// File: rtl/hpc_pkg.sv
package hpc_pkg;

  typedef struct packed {
    logic       run;
    logic [1:0] sel;
    logic       gang;
  } hpc_cfg_t;

  localparam int RUN_POS  = 7;
  localparam int SEL_HI   = 6;
  localparam int SEL_LO   = 5;
  localparam int GANG_POS = 0;
  localparam logic [1:0] SEL_NONE = 2'b11;

  function automatic logic [7:0] cfg_to_byte(hpc_cfg_t c);
    logic [7:0] b;
    b                 = '0;
    b[RUN_POS]        = c.run;
    b[SEL_HI:SEL_LO]  = c.sel;
    b[GANG_POS]       = c.gang;
    return b;
  endfunction

endpackage

// File: rtl/hpc_regfile.sv
module hpc_regfile
  import hpc_pkg::*;
#(
  parameter int               ADDR_W    = 8,
  parameter logic [ADDR_W-1:0] CFG_INDEX = 8'hF7
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic [1:0]        strap_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [7:0]        bus_wdata,
  input  logic              bus_rd,
  output logic [7:0]        bus_rdata,
  output hpc_cfg_t          cfg
);

  logic hit;
  logic unused_rsvd;

  assign hit         = (bus_addr == CFG_INDEX);
  assign unused_rsvd = ^bus_wdata[4:1];

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      cfg.run  <= 1'b0;
      cfg.sel  <= ~strap_n;
      cfg.gang <= 1'b0;
    end else if (bus_wr && hit) begin
      cfg.run  <= bus_wdata[RUN_POS];
      cfg.sel  <= bus_wdata[SEL_HI:SEL_LO];
      cfg.gang <= bus_wdata[GANG_POS];
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_rd && hit) bus_rdata = cfg_to_byte(cfg);
  end

endmodule

// File: rtl/hpc_count_decode.sv
module hpc_count_decode
  import hpc_pkg::*;
#(
  parameter int NPORTS = 4
) (
  input  logic [1:0]        sel,
  output logic [NPORTS-1:0] mask
);

  always_comb begin
    mask = '0;
    if (sel != SEL_NONE) begin
      for (int i = 0; i < NPORTS; i++) begin
        if (i < NPORTS - int'(sel)) mask[i] = 1'b1;
      end
    end
  end

endmodule

// File: rtl/hpc_port_gate.sv
module hpc_port_gate #(
  parameter int NPORTS = 4
) (
  input  logic              gang,
  input  logic [NPORTS-1:0] mask,
  input  logic [NPORTS-1:0] req,
  input  logic [NPORTS-1:0] sense_n,
  output logic [NPORTS-1:0] pwr_n,
  output logic [NPORTS-1:0] flag
);

  logic shared_fault;
  logic shared_req;

  assign shared_fault = |(~sense_n & mask);
  assign shared_req   = |(req & mask);

  for (genvar i = 0; i < NPORTS; i++) begin : g_port
    logic fault_i;
    logic req_i;
    assign fault_i  = gang ? shared_fault : ~sense_n[i];
    assign req_i    = gang ? shared_req   : req[i];
    assign flag[i]  = mask[i] & fault_i;
    assign pwr_n[i] = mask[i] & ~req_i;
  end

endmodule

// File: rtl/hub_port_cfg.sv
module hub_port_cfg
  import hpc_pkg::*;
#(
  parameter int                ADDR_W    = 8,
  parameter int                NPORTS    = 4,
  parameter logic [ADDR_W-1:0] CFG_INDEX = 8'hF7
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic [1:0]        strap_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [7:0]        bus_wdata,
  input  logic              bus_rd,
  output logic [7:0]        bus_rdata,
  input  logic [NPORTS-1:0] pwr_req,
  input  logic [NPORTS-1:0] oc_sense_n,
  output logic              hub_hold,
  output logic [NPORTS-1:0] port_en,
  output logic [NPORTS-1:0] pwr_en_n,
  output logic [NPORTS-1:0] oc_flag
);

  hpc_cfg_t cfg;

  hpc_regfile #(.ADDR_W(ADDR_W), .CFG_INDEX(CFG_INDEX)) u_regs (
    .clk       (clk),
    .por_n     (por_n),
    .strap_n   (strap_n),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .bus_rd    (bus_rd),
    .bus_rdata (bus_rdata),
    .cfg       (cfg)
  );

  hpc_count_decode #(.NPORTS(NPORTS)) u_dec (
    .sel  (cfg.sel),
    .mask (port_en)
  );

  hpc_port_gate #(.NPORTS(NPORTS)) u_gate (
    .gang    (cfg.gang),
    .mask    (port_en),
    .req     (pwr_req),
    .sense_n (oc_sense_n),
    .pwr_n   (pwr_en_n),
    .flag    (oc_flag)
  );

  assign hub_hold = ~cfg.run;

endmodule

// File: rtl/hpc_chk.sv
module hpc_chk #(
  parameter int                ADDR_W    = 8,
  parameter int                NPORTS    = 4,
  parameter logic [ADDR_W-1:0] CFG_INDEX = 8'hF7
) (
  input logic              clk,
  input logic              por_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_wr,
  input logic              wr_run,
  input logic              bus_rd,
  input logic [7:0]        bus_rdata,
  input logic              hub_hold,
  input logic [NPORTS-1:0] port_en,
  input logic [NPORTS-1:0] pwr_en_n,
  input logic [NPORTS-1:0] oc_flag
);

  // R4
  rsvd_read_zero_chk: assert property (@(posedge clk) disable iff (!por_n)
    bus_rdata[4:1] == 4'b0);

  // R4
  idle_read_zero_chk: assert property (@(posedge clk) disable iff (!por_n)
    !(bus_rd && bus_addr == CFG_INDEX) |-> bus_rdata == 8'h00);

  // R7
  off_port_pwr_low_chk: assert property (@(posedge clk) disable iff (!por_n)
    (pwr_en_n & ~port_en) == '0);

  // R8
  off_port_flag_quiet_chk: assert property (@(posedge clk) disable iff (!por_n)
    (oc_flag & ~port_en) == '0);

  // R5
  hold_after_write_chk: assert property (@(posedge clk) disable iff (!por_n)
    (bus_wr && bus_addr == CFG_INDEX) |=> hub_hold == !$past(wr_run));

  // R2
  no_write_stable_chk: assert property (@(posedge clk) disable iff (!por_n)
    !(bus_wr && bus_addr == CFG_INDEX) |=> ($stable(port_en) && $stable(hub_hold)));

endmodule

bind hub_port_cfg hpc_chk #(.ADDR_W(ADDR_W), .NPORTS(NPORTS), .CFG_INDEX(CFG_INDEX)) u_chk (
  .clk       (clk),
  .por_n     (por_n),
  .bus_addr  (bus_addr),
  .bus_wr    (bus_wr),
  .wr_run    (bus_wdata[7]),
  .bus_rd    (bus_rd),
  .bus_rdata (bus_rdata),
  .hub_hold  (hub_hold),
  .port_en   (port_en),
  .pwr_en_n  (pwr_en_n),
  .oc_flag   (oc_flag)
);

// File: tb/tb_hub_port_cfg.sv
module tb_hub_port_cfg;

  logic       clk = 1'b0;
  logic       por_n = 1'b0;
  logic [1:0] strap_n = 2'b11;
  logic [7:0] bus_addr = 8'h00;
  logic       bus_wr = 1'b0;
  logic [7:0] bus_wdata = 8'h00;
  logic       bus_rd = 1'b0;
  logic [7:0] bus_rdata;
  logic [3:0] pwr_req = 4'h0;
  logic [3:0] oc_sense_n = 4'hF;
  logic       hub_hold;
  logic [3:0] port_en, pwr_en_n, oc_flag;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  hub_port_cfg dut (
    .clk(clk), .por_n(por_n), .strap_n(strap_n), .bus_addr(bus_addr),
    .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .pwr_req(pwr_req), .oc_sense_n(oc_sense_n), .hub_hold(hub_hold),
    .port_en(port_en), .pwr_en_n(pwr_en_n), .oc_flag(oc_flag)
  );

  function automatic logic [3:0] exp_mask(logic [1:0] code);
    case (code)
      2'b00:   return 4'b1111;
      2'b01:   return 4'b0111;
      2'b10:   return 4'b0011;
      default: return 4'b0000;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    #1 d = bus_rdata;
    #1 bus_rd = 1'b0;
  endtask

  initial begin
    #2_000_000;
    errors++;
    checks++;
    $display("FAIL watchdog actual=%h expected=%h", 8'h01, 8'h00);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [7:0] rd;
    // R1: reset sampling for every strap combination
    for (int s = 0; s < 4; s++) begin
      @(negedge clk);
      por_n = 1'b0; strap_n = 2'(s);
      #12;
      chk("R1 reset field", {6'b0, ~strap_n}, {6'b0, ~2'(s)});
      @(negedge clk);
      por_n = 1'b1;
      bus_read(8'hF7, rd);
      chk("R1 reset value", rd, {1'b0, ~2'(s), 5'b0});
      chk("R5 hold after reset", {7'b0, hub_hold}, 8'h01);
      chk("R6 mask after reset", {4'b0, port_en}, {4'b0, exp_mask(~2'(s))});
    end
    // R2: straps ignored after reset (last reset left field 00)
    strap_n = 2'b00;
    repeat (3) @(negedge clk);
    bus_read(8'hF7, rd);
    chk("R2 strap ignored", rd, 8'h00);
    chk("R2 mask unchanged", {4'b0, port_en}, 8'h0F);
    // R3: other index ignored
    bus_write(8'hF6, 8'hFF);
    bus_read(8'hF7, rd);
    chk("R3 other index write", rd, 8'h00);
    // R4: other-index read and no-strobe read give 0
    bus_write(8'hF7, 8'hE1);
    bus_read(8'hF6, rd);
    chk("R4 other index read", rd, 8'h00);
    @(negedge clk);
    bus_addr = 8'hF7; bus_rd = 1'b0;
    #1 chk("R4 no strobe", bus_rdata, 8'h00);
    bus_read(8'hF7, rd);
    chk("R3 full write", rd, 8'hE1);
    // Sweep every register setting and every request/sense pattern
    for (int v = 0; v < 16; v++) begin
      logic [7:0] wb;
      logic [3:0] m;
      wb = {v[3], v[2:1], 4'b0, v[0]};
      bus_write(8'hF7, wb | 8'h1E);
      bus_read(8'hF7, rd);
      chk("R3 R4 write/read rsvd", rd, wb);
      chk("R5 hold", {7'b0, hub_hold}, {7'b0, ~v[3]});
      m = exp_mask(v[2:1]);
      chk("R6 mask", {4'b0, port_en}, {4'b0, m});
      for (int r = 0; r < 16; r++) begin
        for (int o = 0; o < 16; o++) begin
          logic [3:0] ep, eo;
          pwr_req = 4'(r); oc_sense_n = 4'(o);
          #1;
          if (v[0]) begin
            eo = (|(~4'(o) & m)) ? m : 4'b0;
            ep = (|(4'(r) & m)) ? 4'b0 : m;
            chk("R10 ganged power", {4'b0, pwr_en_n}, {4'b0, ep});
            chk("R9 ganged fault", {4'b0, oc_flag}, {4'b0, eo});
          end else begin
            eo = ~4'(o) & m;
            ep = ~4'(r) & m;
            chk("R7 port power", {4'b0, pwr_en_n}, {4'b0, ep});
            chk("R8 port fault", {4'b0, oc_flag}, {4'b0, eo});
          end
        end
      end
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule